// File: doc/BRIEF.md
# Stack Call and Return Unit

This unit executes the stack and subroutine instructions of a word-addressed processor. It holds the stack pointer. A fetch stage hands it one decoded operation at a time, together with the address of that instruction and an operand. The operand is a data value for a push, or a branch target for a call. The stack grows toward higher addresses. A push or call first bumps the pointer and then writes at the new top. A pop or return reads the current top and then steps the pointer back.

Each operation makes exactly one memory access. The unit then reports the address of the next instruction, a register writeback for a pop, and the new stack pointer. It also tracks the machine mode. The interrupt-return operation is allowed only in privileged mode. It leaves that mode, turns paging on, and otherwise behaves as a return. If it is issued in unprivileged mode, it raises an illegal-instruction flag and changes nothing.

The fetch stage must hold off while `busy` is high. Memory answers reads one cycle after the request.

Top module: `stack_call_unit`

## Requirements
- R1: After reset, `busy`, `mem_req`, `done` and `illegal` are 0, `sp` is 0, `priv` is 1 and `paging_en` is 0.
- R2: A push (`op_kind` 3'd1) writes `operand` to address `sp`+1, leaves `sp` one higher, and reports `next_ip` = `cur_ip`+2.
- R3: A pop (`op_kind` 3'd2) reads address `sp`, returns the word on `rf_wdata` with `rf_we` high, leaves `sp` one lower, and reports `next_ip` = `cur_ip`+2.
- R4: A call (`op_kind` 3'd3) writes `cur_ip`+2 to address `sp`+1, leaves `sp` one higher, and reports `next_ip` = `operand`.
- R5: A return (`op_kind` 3'd4) reads address `sp`, reports the word read as `next_ip` with `rf_we` low, and leaves `sp` one lower.
- R6: An accepted operation holds `busy` high for two cycles. The memory request comes in the first cycle and `done` in the second. `op_valid` is ignored while `busy` is high.
- R7: An interrupt return (`op_kind` 3'd5) in privileged mode acts as a return and pulses `mode_sw` together with `done`. From the next cycle on, `priv` is 0 and `paging_en` is 1.
- R8: An interrupt return in unprivileged mode makes one cycle with `illegal` and `busy` high. That cycle has no memory request and no `done`. `sp` and the mode are unchanged.
- R9: Stack pointer arithmetic and the `cur_ip`+2 sum wrap modulo 2^16.
- R10: `sp_ld` loads `sp_ld_val` into `sp` in an idle cycle and is ignored while `busy` is high.
- R11: `op_kind` values 3'd0, 3'd6 and 3'd7 are ignored: no `busy` and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| op_valid | input | 1 | operation offered by the fetch stage |
| op_kind | input | 3 | operation code |
| cur_ip | input | 16 | address of the offered instruction |
| operand | input | 16 | push data or call target |
| sp_ld | input | 1 | load stack pointer |
| sp_ld_val | input | 16 | value for stack pointer load |
| busy | output | 1 | unit occupied; fetch must stall |
| mem_req | output | 1 | memory access this cycle |
| mem_we | output | 1 | access is a write |
| mem_addr | output | 16 | access address |
| mem_wdata | output | 16 | write data |
| mem_rdata | input | 16 | read data, one cycle after the request |
| done | output | 1 | operation completes; `next_ip` valid |
| next_ip | output | 16 | next instruction address |
| sp | output | 16 | current stack pointer |
| rf_we | output | 1 | register writeback strobe |
| rf_wdata | output | 16 | register writeback value |
| priv | output | 1 | privileged mode |
| paging_en | output | 1 | paging enabled |
| mode_sw | output | 1 | mode switch happens with this completion |
| illegal | output | 1 | illegal-instruction exception |

## Verification
An operation sampled at clock edge E0 shows its memory request in the cycle after E0. It shows `done`, `next_ip` and any writeback in the cycle after E1, by which time `sp` already holds its new value. The mode flags change at E2. The bench samples on the falling edge of each of those three cycles in turn, so every result is compared in the one cycle it is due. An illegal interrupt return is due one cycle after acceptance. Ignored inputs are judged by whether `busy`, `mem_req` and `sp` stay put on the following cycles.

// File: rtl/scu_pkg.sv
package scu_pkg;
   typedef enum logic [2:0] {
      OPK_NONE = 3'd0,
      OPK_PUSH = 3'd1,
      OPK_POP  = 3'd2,
      OPK_CALL = 3'd3,
      OPK_RET  = 3'd4,
      OPK_IRET = 3'd5
   } scu_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_MEM,
      ST_WB,
      ST_FLT
   } scu_st_e;
endpackage

// File: rtl/scu_sp.sv
module scu_sp #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [AW-1:0] ld_val,
   input  logic          step_up,
   input  logic          step_dn,
   output logic [AW-1:0] sp_q,
   output logic [AW-1:0] sp_up
);
   localparam logic [AW-1:0] ONE = AW'(1);

   assign sp_up = sp_q + ONE;

   always_ff @(posedge clk) begin
      if (!rst_n)       sp_q <= '0;
      else if (ld)      sp_q <= ld_val;
      else if (step_up) sp_q <= sp_up;
      else if (step_dn) sp_q <= sp_q - ONE;
   end

   // R10
   sp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld && (step_up || step_dn)) && !(step_up && step_dn));
endmodule

// File: rtl/scu_ctrl.sv
module scu_ctrl
   import scu_pkg::*;
#(
   parameter int AW   = 16,
   parameter int DW   = 16,
   parameter int ILEN = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   input  logic [2:0]    op_kind,
   input  logic [AW-1:0] cur_ip,
   input  logic [DW-1:0] operand,
   input  logic          sp_ld,
   input  logic [AW-1:0] sp_q,
   input  logic [AW-1:0] sp_up,
   input  logic [DW-1:0] mem_rdata,
   output logic          ld_en,
   output logic          step_up,
   output logic          step_dn,
   output logic          busy,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          done,
   output logic [AW-1:0] next_ip,
   output logic          rf_we,
   output logic [DW-1:0] rf_wdata,
   output logic          priv,
   output logic          paging_en,
   output logic          mode_sw,
   output logic          illegal
);
   localparam logic [AW-1:0] STEP = AW'(ILEN);

   scu_st_e       st_q;
   scu_op_e       op_q;
   logic [AW-1:0] ip_q;
   logic [DW-1:0] opd_q;
   logic          priv_q, pg_q;
   logic          known, accept, grows;
   logic [AW-1:0] ip_next_seq;
   logic [DW-1:0] ret_word;

   assign known  = (op_kind >= 3'd1) && (op_kind <= 3'd5);
   assign accept = (st_q == ST_IDLE) && op_valid && known;
   assign grows  = (op_q == OPK_PUSH) || (op_q == OPK_CALL);
   assign ip_next_seq = ip_q + STEP;

   generate
      if (DW > AW) begin : g_wide
         assign ret_word = {{(DW-AW){1'b0}}, ip_next_seq};
      end else begin : g_same
         assign ret_word = ip_next_seq;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         op_q   <= OPK_NONE;
         ip_q   <= '0;
         opd_q  <= '0;
         priv_q <= 1'b1;
         pg_q   <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (accept) begin
               op_q  <= scu_op_e'(op_kind);
               ip_q  <= cur_ip;
               opd_q <= operand;
               st_q  <= (scu_op_e'(op_kind) == OPK_IRET && !priv_q) ? ST_FLT : ST_MEM;
            end
            ST_MEM:  st_q <= ST_WB;
            ST_WB: begin
               st_q <= ST_IDLE;
               if (op_q == OPK_IRET) begin
                  priv_q <= 1'b0;
                  pg_q   <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ld_en     = (st_q == ST_IDLE) && sp_ld;
      step_up   = (st_q == ST_MEM) && grows;
      step_dn   = (st_q == ST_MEM) && !grows;
      busy      = (st_q != ST_IDLE);
      mem_req   = (st_q == ST_MEM);
      mem_we    = (st_q == ST_MEM) && grows;
      mem_addr  = grows ? sp_up : sp_q;
      mem_wdata = (op_q == OPK_CALL) ? ret_word : opd_q;
      done      = (st_q == ST_WB);
      rf_we     = (st_q == ST_WB) && (op_q == OPK_POP);
      rf_wdata  = mem_rdata;
      mode_sw   = (st_q == ST_WB) && (op_q == OPK_IRET);
      illegal   = (st_q == ST_FLT);
      case (op_q)
         OPK_CALL:          next_ip = opd_q[AW-1:0];
         OPK_RET, OPK_IRET: next_ip = mem_rdata[AW-1:0];
         default:           next_ip = ip_next_seq;
      endcase
   end

   assign priv      = priv_q;
   assign paging_en = pg_q;

   // R6
   req_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> done && busy);
   // R6
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !illegal && !done) |=> (busy && done));
   // R7
   mode_after_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sw |=> (!priv && paging_en));
   // R7
   priv_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(priv) |-> $past(mode_sw));
   // R8
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!mem_req && !done && !priv && busy));
   // R3
   wb_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> done);
endmodule

// File: rtl/stack_call_unit.sv
module stack_call_unit #(
   parameter int AW   = 16,
   parameter int DW   = 16,
   parameter int ILEN = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   input  logic [2:0]    op_kind,
   input  logic [AW-1:0] cur_ip,
   input  logic [DW-1:0] operand,
   input  logic          sp_ld,
   input  logic [AW-1:0] sp_ld_val,
   output logic          busy,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          done,
   output logic [AW-1:0] next_ip,
   output logic [AW-1:0] sp,
   output logic          rf_we,
   output logic [DW-1:0] rf_wdata,
   output logic          priv,
   output logic          paging_en,
   output logic          mode_sw,
   output logic          illegal
);
   generate
      if (DW < AW) begin : g_bad_dw
         $error("stack_call_unit: DW must hold a full IP");
      end
      if (ILEN < 1) begin : g_bad_ilen
         $error("stack_call_unit: ILEN must be positive");
      end
   endgenerate

   logic          ld_en, step_up, step_dn;
   logic [AW-1:0] sp_up;

   scu_sp #(.AW(AW)) u_sp (
      .clk(clk), .rst_n(rst_n), .ld(ld_en), .ld_val(sp_ld_val),
      .step_up(step_up), .step_dn(step_dn), .sp_q(sp), .sp_up(sp_up)
   );

   scu_ctrl #(.AW(AW), .DW(DW), .ILEN(ILEN)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .cur_ip(cur_ip), .operand(operand), .sp_ld(sp_ld), .sp_q(sp),
      .sp_up(sp_up), .mem_rdata(mem_rdata), .ld_en(ld_en),
      .step_up(step_up), .step_dn(step_dn), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .done(done), .next_ip(next_ip),
      .rf_we(rf_we), .rf_wdata(rf_wdata), .priv(priv),
      .paging_en(paging_en), .mode_sw(mode_sw), .illegal(illegal)
   );

   // R2
   push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |=> (sp == $past(mem_addr)));
   // R9
   pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> (sp == $past(mem_addr) - AW'(1)));
endmodule

// File: tb/sim_stack_call_unit.sv
`timescale 1ns/1ps
module sim_stack_call_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_kind = 3'd0;
   logic [15:0] cur_ip = '0, operand = '0, sp_ld_val = '0;
   logic        sp_ld = 1'b0;
   logic        busy, mem_req, mem_we, done, rf_we, priv, paging_en, mode_sw, illegal;
   logic [15:0] mem_addr, mem_wdata, next_ip, sp, rf_wdata;
   logic [15:0] mem_rdata = '0;
   logic [15:0] bmem [256];

   int total = 0, bad = 0, cyc = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   stack_call_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .cur_ip(cur_ip), .operand(operand), .sp_ld(sp_ld), .sp_ld_val(sp_ld_val),
      .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
      .next_ip(next_ip), .sp(sp), .rf_we(rf_we), .rf_wdata(rf_wdata),
      .priv(priv), .paging_en(paging_en), .mode_sw(mode_sw), .illegal(illegal)
   );

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
         else        mem_rdata <= bmem[mem_addr[7:0]];
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   logic        m_busy, m_req, m_we, m_ill;
   logic [15:0] m_addr, m_wdata;
   logic        w_done, w_rfwe, w_msw, w_busy;
   logic [15:0] w_nip, w_rfd, w_sp;
   logic        f_busy, f_priv, f_pg;
   logic [15:0] f_sp;

   task automatic run_op(input logic [2:0] k, input logic [15:0] ip, input logic [15:0] opd);
      @(negedge clk);
      op_kind = k; cur_ip = ip; operand = opd; op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      m_busy = busy; m_req = mem_req; m_we = mem_we; m_ill = illegal;
      m_addr = mem_addr; m_wdata = mem_wdata;
      @(negedge clk);
      w_done = done; w_rfwe = rf_we; w_msw = mode_sw; w_busy = busy;
      w_nip = next_ip; w_rfd = rf_wdata; w_sp = sp;
      @(negedge clk);
      f_busy = busy; f_priv = priv; f_pg = paging_en; f_sp = sp;
   endtask

   task automatic load_sp(input logic [15:0] v);
      @(negedge clk);
      sp_ld = 1'b1; sp_ld_val = v;
      @(negedge clk);
      sp_ld = 1'b0;
   endtask

   localparam int NV = 8;
   localparam logic [2:0]  V_K   [NV] = '{3'd1, 3'd1, 3'd3, 3'd3, 3'd4, 3'd4, 3'd2, 3'd2};
   localparam logic [15:0] V_IP  [NV] = '{16'h0100, 16'h0102, 16'h0104, 16'h2010,
                                          16'h3008, 16'h2014, 16'h0106, 16'h0108};
   localparam logic [15:0] V_OPD [NV] = '{16'hAAAA, 16'h5555, 16'h2000, 16'h3000,
                                          16'h0000, 16'h0000, 16'h0000, 16'h0000};
   localparam logic [15:0] V_AD  [NV] = '{16'h1001, 16'h1002, 16'h1003, 16'h1004,
                                          16'h1004, 16'h1003, 16'h1002, 16'h1001};
   localparam logic        V_WE  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
   localparam logic [15:0] V_WD  [NV] = '{16'hAAAA, 16'h5555, 16'h0106, 16'h2012,
                                          16'h0000, 16'h0000, 16'h0000, 16'h0000};
   localparam logic [15:0] V_NIP [NV] = '{16'h0102, 16'h0104, 16'h2000, 16'h3000,
                                          16'h2012, 16'h0106, 16'h0108, 16'h010A};
   localparam logic [15:0] V_SP  [NV] = '{16'h1001, 16'h1002, 16'h1003, 16'h1004,
                                          16'h1003, 16'h1002, 16'h1001, 16'h1000};
   localparam logic [15:0] V_RF  [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000,
                                          16'h0000, 16'h0000, 16'h5555, 16'hAAAA};

   initial begin
      for (int i = 0; i < 256; i++) bmem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 mem_req", mem_req, 0);
      chk("R1 done", done, 0);
      chk("R1 illegal", illegal, 0);
      chk("R1 sp", sp, 0);
      chk("R1 priv", priv, 1);
      chk("R1 paging", paging_en, 0);

      // R10 load in idle
      load_sp(16'h1000);
      chk("R10 load", sp, 16'h1000);

      // vector table: nested pushes, calls, returns, pops (R2 R3 R4 R5 R6)
      for (int i = 0; i < NV; i++) begin
         string rq;
         case (V_K[i])
            3'd1: rq = "R2";
            3'd2: rq = "R3";
            3'd3: rq = "R4";
            default: rq = "R5";
         endcase
         run_op(V_K[i], V_IP[i], V_OPD[i]);
         chk({rq, " R6 busy1"}, m_busy, 1);
         chk({rq, " R6 req"}, m_req, 1);
         chk({rq, " we"}, m_we, V_WE[i]);
         chk({rq, " addr"}, m_addr, V_AD[i]);
         if (V_WE[i]) chk({rq, " wdata"}, m_wdata, V_WD[i]);
         chk({rq, " R6 done"}, w_done, 1);
         chk({rq, " R6 busy2"}, w_busy, 1);
         chk({rq, " next_ip"}, w_nip, V_NIP[i]);
         chk({rq, " rf_we"}, w_rfwe, (V_K[i] == 3'd2));
         if (V_K[i] == 3'd2) chk({rq, " rf_wdata"}, w_rfd, V_RF[i]);
         chk({rq, " sp"}, f_sp, V_SP[i]);
         chk({rq, " R6 idle"}, f_busy, 0);
      end

      // R6: op_valid held during busy is ignored
      @(negedge clk);
      op_kind = 3'd1; cur_ip = 16'h0200; operand = 16'h7777; op_valid = 1'b1;
      @(negedge clk);
      op_kind = 3'd2;
      @(negedge clk);
      @(negedge clk);
      op_valid = 1'b0;
      chk("R6 no second op busy", busy, 0);
      chk("R6 no second op sp", sp, 16'h1001);
      @(negedge clk);
      chk("R6 still idle", busy, 0);
      chk("R6 sp kept", sp, 16'h1001);

      // R10: sp_ld during busy ignored
      @(negedge clk);
      op_kind = 3'd2; cur_ip = 16'h0202; op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0; sp_ld = 1'b1; sp_ld_val = 16'h4444;
      @(negedge clk);
      @(negedge clk);
      sp_ld = 1'b0;
      chk("R10 busy load ignored", sp, 16'h1000);

      // R11: unknown codes ignored
      foreach (V_K[j]) begin end
      for (int c = 0; c < 3; c++) begin
         logic [2:0] kc;
         kc = (c == 0) ? 3'd0 : ((c == 1) ? 3'd6 : 3'd7);
         @(negedge clk);
         op_kind = kc; op_valid = 1'b1;
         @(negedge clk);
         op_valid = 1'b0;
         chk("R11 busy", busy, 0);
         chk("R11 mem_req", mem_req, 0);
         @(negedge clk);
         chk("R11 sp", sp, 16'h1000);
      end

      // R9: wrap of sp and ip
      load_sp(16'hFFFF);
      run_op(3'd1, 16'h0010, 16'h1234);
      chk("R9 push addr", m_addr, 16'h0000);
      chk("R9 push sp", f_sp, 16'h0000);
      run_op(3'd2, 16'h0012, 16'h0000);
      chk("R9 pop data", w_rfd, 16'h1234);
      chk("R9 pop sp", f_sp, 16'hFFFF);
      run_op(3'd3, 16'hFFFE, 16'h0040);
      chk("R9 call saved", m_wdata, 16'h0000);
      chk("R9 call addr", m_addr, 16'h0000);
      chk("R9 call nip", w_nip, 16'h0040);
      run_op(3'd1, 16'hFFFE, 16'h0000);
      chk("R9 push nip", w_nip, 16'h0000);

      // R7: privileged interrupt return
      load_sp(16'h0020);
      run_op(3'd1, 16'h0300, 16'h0400);
      run_op(3'd5, 16'h0302, 16'h0000);
      chk("R7 read addr", m_addr, 16'h0021);
      chk("R7 read", m_we, 0);
      chk("R7 done", w_done, 1);
      chk("R7 mode_sw", w_msw, 1);
      chk("R7 next_ip", w_nip, 16'h0400);
      chk("R7 sp", f_sp, 16'h0020);
      chk("R7 priv", f_priv, 0);
      chk("R7 paging", f_pg, 1);

      // R8: interrupt return in unprivileged mode
      @(negedge clk);
      op_kind = 3'd5; cur_ip = 16'h0402; op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      chk("R8 illegal", illegal, 1);
      chk("R8 busy", busy, 1);
      chk("R8 no req", mem_req, 0);
      chk("R8 no done", done, 0);
      @(negedge clk);
      chk("R8 idle", busy, 0);
      chk("R8 illegal drop", illegal, 0);
      chk("R8 sp", sp, 16'h0020);
      chk("R8 priv", priv, 0);
      chk("R8 paging", paging_en, 1);

      // R1: reset returns to privileged mode
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 re-reset priv", priv, 1);
      chk("R1 re-reset paging", paging_en, 0);
      chk("R1 re-reset sp", sp, 0);

      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule